// File: doc/BRIEF.md
# Rotating and Sign-Extending Shift Register

This block is a small register with four operating modes chosen by a two-bit select. On each rising clock edge the register keeps its value, moves every bit one place toward the LSB while the MSB is copied into itself, moves every bit one place toward the MSB while the old MSB wraps into the LSB, or takes a new parallel word. Neither shift mode has a serial input, because each takes its fill bit from the register itself.

The width is a parameter with a default of 3. Each bit's next value comes from its own four-way selector, chosen by the mode: `MODE_KEEP` (select 00), `MODE_ASR` (select 01), `MODE_ROL` (select 10) and `MODE_LOAD` (select 11). All four modes can follow one another freely, and any mode can follow any other on the next edge. A synchronous reset overrides the mode.

Top module: `rotshift_reg`

## Requirements
- R1: When `rst` is high at a rising edge, `q` becomes all zeros, whatever `sel` and `din` are.
- R2: With `sel` = 00 at a rising edge, `q` keeps its previous value.
- R3: With `sel` = 01, `q` shifts one place toward the LSB. The MSB keeps its old value, each lower bit i takes old bit i+1, and the old LSB is discarded. For width 3 the result is {q2,q2,q1}.
- R4: With `sel` = 10, `q` rotates one place toward the MSB, and the old MSB enters bit 0. For width 3 the result is {q1,q0,q2}.
- R5: With `sel` = 11, `q` takes the value of `din`.
- R6: `din` has no effect on `q` when `sel` is 00, 01 or 10.
- R7: After WIDTH-1 consecutive `sel` = 01 edges, every bit of `q` equals the MSB held before the first of them.
- R8: WIDTH consecutive `sel` = 10 edges give back the starting value, and every rotate keeps the number of ones unchanged.
- R9: `q` changes only at a rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates happen on its rising edge |
| rst | input | 1 | Synchronous active-high clear; overrides `sel` |
| sel | input | 2 | Mode: 00 keep, 01 arithmetic right, 10 rotate left, 11 load |
| din | input | WIDTH | Parallel word captured in load mode |
| q | output | WIDTH | Current register contents |

## Verification
The assertions check every single-edge transition on each cycle: clearing on reset, keeping in mode 00, the bit mapping of the arithmetic shift with its unchanged sign bit, the wrapped bit and unchanged population count of the rotate, and the capture in load mode. Properties that span many edges need the bench's directed runs. These are the convergence to all sign bits after WIDTH-1 shifts, the return to the starting value after a full circle of rotates, and the lack of effect of `din` across long non-load sequences. The random phase also covers the order of mode changes and reset while load is selected.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
    typedef enum logic [1:0] {
        MODE_KEEP = 2'b00,
        MODE_ASR  = 2'b01,
        MODE_ROL  = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;
endpackage

// File: rtl/rsr_bit_mux.sv
// Next-value selector for one register bit. The neighbours are wired
// by the parent, so this cell needs no knowledge of its position.
module rsr_bit_mux
    import rsr_pkg::*;
(
    input  mode_e mode,
    input  logic  self_bit,
    input  logic  upper_bit,   // source for the arithmetic right shift
    input  logic  lower_bit,   // source for the left rotate
    input  logic  load_bit,
    output logic  nxt_bit
);
    always_comb begin
        unique case (mode)
            MODE_KEEP: nxt_bit = self_bit;
            MODE_ASR:  nxt_bit = upper_bit;
            MODE_ROL:  nxt_bit = lower_bit;
            MODE_LOAD: nxt_bit = load_bit;
            default:   nxt_bit = self_bit;
        endcase
    end
endmodule

// File: rtl/rsr_state_reg.sv
// Storage for the register contents, with a synchronous clear.
module rsr_state_reg #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end
endmodule

// File: rtl/rotshift_reg.sv
module rotshift_reg
    import rsr_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam int MSB = WIDTH - 1;

    mode_e            mode_s;
    logic [WIDTH-1:0] cur_s;
    logic [WIDTH-1:0] nxt_s;

    assign mode_s = mode_e'(sel);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            // The sign bit feeds itself when shifting right, and the old MSB wraps into bit 0 when rotating.
            localparam int UP = (i == MSB) ? MSB : i + 1;
            localparam int DN = (i == 0)   ? MSB : i - 1;
            rsr_bit_mux u_mux (
                .mode      (mode_s),
                .self_bit  (cur_s[i]),
                .upper_bit (cur_s[UP]),
                .lower_bit (cur_s[DN]),
                .load_bit  (din[i]),
                .nxt_bit   (nxt_s[i])
            );
        end
    endgenerate

    rsr_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_s),
        .cur (cur_s)
    );

    assign q = cur_s;
endmodule

// File: rtl/rotshift_reg_chk.sv
module rotshift_reg_chk #(
    parameter int WIDTH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       sel,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R2
    keep_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && sel == 2'b00) |=> (q == $past(q)));

    // R3
    asr_map_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && sel == 2'b01) |=> (q == {$past(q[WIDTH-1]), $past(q[WIDTH-1:1])}));

    // R3
    asr_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && sel == 2'b01) |=> (q[WIDTH-1] == $past(q[WIDTH-1])));

    // R4
    rol_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && sel == 2'b10) |=> (q[0] == $past(q[WIDTH-1])));

    // R8
    rol_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && sel == 2'b10) |=> ($countones(q) == $countones($past(q))));

    // R5
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && sel == 2'b11) |=> (q == $past(din)));
endmodule

bind rotshift_reg rotshift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk (clk),
    .rst (rst),
    .sel (sel),
    .din (din),
    .q   (q)
);

// File: tb/rotshift_reg_bench.sv
`timescale 1ns/1ps
module rotshift_reg_bench;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   sel;
    logic [W-1:0] din;
    logic [W-1:0] q;

    int n_vec  = 0;
    int n_fail = 0;
    logic [W-1:0] model;

    rotshift_reg #(.WIDTH(W)) u_rotshift_reg (
        .clk (clk), .rst (rst), .sel (sel), .din (din), .q (q)
    );

    always #2.5 clk = ~clk;

    function automatic logic [W-1:0] ref_next(logic [W-1:0] c, logic r,
                                              logic [1:0] m, logic [W-1:0] d);
        logic [W-1:0] n;
        if (r) return '0;
        case (m)
            2'b00: n = c;
            2'b01: begin
                n[W-1] = c[W-1];
                for (int k = 0; k < W-1; k++) n[k] = c[k+1];
            end
            2'b10: begin
                n[0] = c[W-1];
                for (int k = 1; k < W; k++) n[k] = c[k-1];
            end
            default: n = d;
        endcase
        return n;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b", tag, act, exp);
        end
    endtask

    // Drive away from the edge, then sample one time unit after it.
    task automatic step(string tag, logic r, logic [1:0] m, logic [W-1:0] d);
        @(negedge clk);
        rst = r; sel = m; din = d;
        model = ref_next(model, r, m, d);
        @(posedge clk);
        #1;
        check(tag, q, model);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: q=%b expected completion", q);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] start;
        rst = 1'b1; sel = 2'b11; din = 3'b111;
        model = '0;
        step("R1 reset with load selected", 1'b1, 2'b11, 3'b111);
        check("R1 literal zero", q, 3'b000);

        step("R5 load", 1'b0, 2'b11, 3'b101);
        step("R3 asr from 101", 1'b0, 2'b01, 3'b000);
        check("R3 literal {q2,q2,q1}", q, 3'b110);
        step("R3 asr again", 1'b0, 2'b01, 3'b010);
        check("R7 all sign bits after W-1 shifts", q, 3'b111);

        step("R5 load 011", 1'b0, 2'b11, 3'b011);
        step("R7 asr 1", 1'b0, 2'b01, 3'b111);
        step("R7 asr 2", 1'b0, 2'b01, 3'b111);
        check("R7 positive converges to zero", q, 3'b000);

        step("R5 load 001", 1'b0, 2'b11, 3'b001);
        step("R4 rol from 001", 1'b0, 2'b10, 3'b111);
        check("R4 literal {q1,q0,q2}", q, 3'b010);
        step("R5 load 110", 1'b0, 2'b11, 3'b110);
        step("R4 rol wrap", 1'b0, 2'b10, 3'b000);
        check("R4 literal msb wraps", q, 3'b101);
        step("R8 rol 2", 1'b0, 2'b10, 3'b010);
        step("R8 rol 3", 1'b0, 2'b10, 3'b100);
        check("R8 full circle restores 110", q, 3'b110);

        for (int k = 0; k < 4; k++) begin
            step("R6 keep with changing din", 1'b0, 2'b00, W'(k * 3 + 1));
            check("R2/R6 keep value", q, 3'b110);
        end

        step("R1 reset over asr", 1'b1, 2'b01, 3'b101);
        check("R1 cleared", q, 3'b000);

        void'($urandom(32'd24680));
        for (int k = 0; k < 400; k++) begin
            logic r;
            logic [1:0] m;
            logic [W-1:0] d;
            r = ($urandom % 20) == 0;
            m = 2'($urandom);
            d = W'($urandom);
            step("R2-mix random mode sequence", r, m, d);
        end

        // Rotate circle and sign convergence from random starting values.
        for (int k = 0; k < 20; k++) begin
            start = W'($urandom);
            step("R5 random load", 1'b0, 2'b11, start);
            for (int j = 0; j < W; j++)
                step("R8 rotate step", 1'b0, 2'b10, W'($urandom));
            check("R8 random circle", q, start);
            for (int j = 0; j < W-1; j++)
                step("R7 asr step", 1'b0, 2'b01, W'($urandom));
            check("R7 random convergence", q, {W{start[W-1]}});
        end

        // R9: no change between edges.
        @(negedge clk);
        sel = 2'b11; din = ~q;
        start = q;
        #1;
        check("R9 no change before edge", q, start);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule